// File: doc/BRIEF.md
# Microwire Half-Duplex Serial Master

This block is a serial master for command/response transactions of the Microwire kind. Software places an 8-bit control byte in a transmit queue. Each byte starts one frame. Chip select goes low and the byte is shifted out most significant bit first. The master then idles for one serial clock so the slave can decode the command. After that it shifts in a reply of 4 to 16 bits and places the reply, right-justified, in a receive queue.

The serial clock comes from the system clock. Its half period is a programmable number of system clock cycles, so the full period is always an even divide. If the transmit queue still holds bytes when a frame ends, the next frame follows with chip select held low. Both queues are eight entries deep. A push to a full queue is dropped. A reply that finds the receive queue full sets a sticky overrun flag.

Top module: `mw_master`

## Requirements
- R1: While no frame is in progress, `sk` is 0, `cs_n` is 1, `so` is 0 and `busy` is 0. These are also the levels after reset, when both queues are empty and `rx_overrun` is 0.
- R2: When the block is idle, a byte pushed into an empty transmit queue makes `cs_n` fall on the second rising `clk` edge after the push. At that point `so` already shows bit 7 of the byte. The eight control bits go out bit 7 first and change only after a falling `sk` edge, so they are stable when `sk` rises.
- R3: After the eighth control bit comes one turnaround `sk` cycle. The reply bits follow it. A frame is 9+L rising `sk` edges long, and `so` is 0 from the turnaround to the end of the frame.
- R4: The reply length L is `reply_len`, sampled when a frame starts. Values below 4 count as 4 and values above 16 count as 16.
- R5: The master samples `si` on each rising `sk` edge of the reply, most significant bit first. The reply goes into the receive queue right-justified in `rx_data`, with all bits above L at 0.
- R6: If the transmit queue is not empty when a frame ends, the next frame starts with `cs_n` kept low. Otherwise `cs_n` rises.
- R7: Each `sk` half period lasts `sk_half` system clock cycles. A value of 0 counts as 1. The value is sampled when a frame starts.
- R8: Each queue holds 8 entries and returns them in push order. `rx_data` shows the oldest receive entry. `tx_full`, `tx_empty`, `rx_full` and `rx_empty` show the fill state. A push to a full transmit queue is dropped.
- R9: If a reply completes while the receive queue is full, the reply is discarded and `rx_overrun` becomes 1 and stays 1 until reset.
- R10: `busy` is 1 from the falling edge of `cs_n` until `cs_n` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_push | input | 1 | Push `tx_data` into the transmit queue |
| tx_data | input | 8 | Control byte |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_pop | input | 1 | Remove the oldest receive entry |
| rx_data | output | 16 | Oldest reply, right-justified |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_overrun | output | 1 | Sticky: a reply was lost to a full receive queue |
| reply_len | input | 5 | Reply length in bits (clamped to 4..16) |
| sk_half | input | 8 | `sk` half period in `clk` cycles (0 counts as 1) |
| busy | output | 1 | Frame in progress |
| sk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| so | output | 1 | Serial data to the slave |
| si | input | 1 | Serial data from the slave |

## Verification
The hardest states to reach are the ones where both queues are stressed at once: a full transmit queue that drops a push, back-to-back frames with chip select never rising, and a reply arriving while the receive queue is full. The bench reaches them by pushing ten bytes on consecutive cycles with the shortest reply and fastest clock, and by leaving the receive queue unread. Nine frames then run without a gap, and the ninth reply overruns. A model slave tied to the pins captures each command and answers with an arithmetic function of it. This lets every reply length and divider setting in the sweep be checked against a value computed in the bench.

// File: rtl/mw_master.sv
module mw_master #(
  parameter int DEPTH = 8,
  parameter int DIV_W = 8,
  parameter int MAXL  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_push,
  input  logic [7:0]       tx_data,
  output logic             tx_full,
  output logic             tx_empty,
  input  logic             rx_pop,
  output logic [MAXL-1:0]  rx_data,
  output logic             rx_full,
  output logic             rx_empty,
  output logic             rx_overrun,
  input  logic [4:0]       reply_len,
  input  logic [DIV_W-1:0] sk_half,
  output logic             busy,
  output logic             sk,
  output logic             cs_n,
  output logic             so,
  input  logic             si
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = AW + 1;
  localparam int LW  = 5;
  localparam int CYW = LW + 1;

  // transmit queue
  logic [7:0]    txm [DEPTH];
  logic [AW-1:0] txw, txr;
  logic [CW-1:0] txc;
  logic          tx_wr, tx_rd;

  // receive queue
  logic [MAXL-1:0] rxm [DEPTH];
  logic [AW-1:0]   rxw, rxr;
  logic [CW-1:0]   rxc;
  logic            rx_wr, rx_rd, rx_done;

  // frame engine
  logic             act, sk_q;
  logic [7:0]       sh;
  logic [MAXL-1:0]  rsh;
  logic [LW-1:0]    len_q, eff_len;
  logic [DIV_W-1:0] half_q, eff_half, dcnt;
  logic [CYW-1:0]   cyc;
  logic             tick, last, start;

  assign tx_full  = (txc == CW'(DEPTH));
  assign tx_empty = (txc == '0);
  assign rx_full  = (rxc == CW'(DEPTH));
  assign rx_empty = (rxc == '0);
  assign tx_wr    = tx_push && !tx_full;
  assign rx_rd    = rx_pop && !rx_empty;
  assign rx_data  = rxm[rxr];

  always_comb begin
    if (reply_len < LW'(4))         eff_len = LW'(4);
    else if (reply_len > LW'(MAXL)) eff_len = LW'(MAXL);
    else                            eff_len = reply_len;
  end
  assign eff_half = (sk_half == '0) ? DIV_W'(1) : sk_half;

  assign tick    = act && (dcnt == half_q - DIV_W'(1));
  assign last    = tick && sk_q && (cyc == CYW'(len_q) + CYW'(8));
  assign start   = (!act || last) && !tx_empty;
  assign tx_rd   = start;
  assign rx_done = last;
  assign rx_wr   = rx_done && !rx_full;

  assign busy = act;
  assign cs_n = !act;
  assign sk   = sk_q;
  assign so   = act && (cyc < CYW'(8)) && sh[7];

  always_ff @(posedge clk) begin
    if (tx_wr) txm[txw] <= tx_data;
    if (rx_wr) rxm[rxw] <= rsh;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txw <= '0; txr <= '0; txc <= '0;
      rxw <= '0; rxr <= '0; rxc <= '0;
      rx_overrun <= 1'b0;
    end else begin
      if (tx_wr) txw <= txw + AW'(1);
      if (tx_rd) txr <= txr + AW'(1);
      txc <= txc + CW'(tx_wr) - CW'(tx_rd);
      if (rx_wr) rxw <= rxw + AW'(1);
      if (rx_rd) rxr <= rxr + AW'(1);
      rxc <= rxc + CW'(rx_wr) - CW'(rx_rd);
      if (rx_done && rx_full) rx_overrun <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= 1'b0; sk_q <= 1'b0; sh <= '0; rsh <= '0;
      len_q <= LW'(4); half_q <= DIV_W'(1); dcnt <= '0; cyc <= '0;
    end else if (start) begin
      act <= 1'b1; sk_q <= 1'b0; sh <= txm[txr]; rsh <= '0;
      len_q <= eff_len; half_q <= eff_half; dcnt <= '0; cyc <= '0;
    end else if (last) begin
      act <= 1'b0; sk_q <= 1'b0; dcnt <= '0;
    end else if (act) begin
      if (tick) begin
        dcnt <= '0;
        sk_q <= !sk_q;
        if (!sk_q) begin
          if (cyc > CYW'(8)) rsh <= {rsh[MAXL-2:0], si};
        end else begin
          cyc <= cyc + CYW'(1);
          if (cyc < CYW'(8)) sh <= {sh[6:0], 1'b0};
        end
      end else begin
        dcnt <= dcnt + DIV_W'(1);
      end
    end
  end

  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> (!sk && !so && !busy)); // R1
  AST_SO_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n) (tick && !sk_q) |=> $stable(so)); // R2
  AST_START_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> $past(!tx_empty)); // R2
  AST_QUIET_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n) (act && cyc >= CYW'(8)) |-> !so); // R3
  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) txc <= CW'(DEPTH)); // R8
  AST_TX_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n) (tx_push && tx_full && !tx_rd) |=> tx_full); // R8
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n) (rx_done && rx_full) |=> (rx_overrun && rx_full)); // R9
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) rx_overrun |=> rx_overrun); // R9
endmodule

// File: tb/mw_master_tb_top.sv
module mw_master_tb_top;
  logic clk = 0, rst_n = 0;
  logic tx_push = 0, rx_pop = 0, si = 0;
  logic [7:0] tx_data = 0, sk_half = 1;
  logic [4:0] reply_len = 4;
  logic tx_full, tx_empty, rx_full, rx_empty, rx_overrun, busy, sk, cs_n, so;
  logic [15:0] rx_data;
  int npass = 0, nfail = 0;

  always #5 clk = ~clk;

  mw_master dut_i (
    .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .tx_data(tx_data),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_pop(rx_pop), .rx_data(rx_data),
    .rx_full(rx_full), .rx_empty(rx_empty), .rx_overrun(rx_overrun),
    .reply_len(reply_len), .sk_half(sk_half), .busy(busy), .sk(sk),
    .cs_n(cs_n), .so(so), .si(si)
  );

  function automatic logic [15:0] expv(logic [7:0] c, int l);
    logic [16:0] m;
    m = (17'd1 << l) - 17'd1;
    return (16'(c) * 16'd181 + 16'h03C5) & m[15:0];
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    if (ok) npass++;
    else begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // slave model
  int cur_len = 4, rises = 0, total_rises = 0, ncmd = 0, so_bad = 0, cs_rises = 0;
  logic [7:0] cap = 0;
  logic [7:0] cmd_log [0:127];
  logic [15:0] reply = 0;
  time t_rise = 0, last_hp = 0;

  always @(posedge sk) begin
    rises++; total_rises++; t_rise = $time;
    if (rises <= 8) cap = {cap[6:0], so};
    else if (so) so_bad++;
    if (rises == 8) begin
      cmd_log[ncmd] = cap; ncmd++;
      reply = expv(cap, cur_len);
    end
  end
  always @(negedge sk) begin
    last_hp = $time - t_rise;
    if (rises >= 9 && rises < 9 + cur_len) si = reply[cur_len - 1 - (rises - 9)];
    else si = 1'b0;
    if (rises == 9 + cur_len) rises = 0;
  end
  always @(negedge cs_n) rises = 0;
  always @(posedge cs_n) cs_rises++;

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", npass, npass + nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(sk == 0 && cs_n == 1 && so == 0 && busy == 0, "R1 idle pins", {sk, cs_n, so, busy}, 4'b0100);
    chk(tx_empty && rx_empty && !tx_full && !rx_full && !rx_overrun, "R1 reset flags", {tx_empty, rx_empty}, 3);

    // sweep of divider and reply length, including clamped lengths
    for (int h = 0; h <= 3; h++) begin
      for (int l = 2; l <= 18; l++) begin
        automatic int el = (l < 4) ? 4 : (l > 16) ? 16 : l;
        automatic int eh = (h == 0) ? 1 : h;
        automatic logic [7:0] c = 8'(h * 61 + l * 13 + 7);
        automatic int tr0;
        automatic int nc0 = ncmd;
        reply_len = 5'(l); sk_half = 8'(h); cur_len = el;
        tx_data = c; tx_push = 1;
        @(negedge clk); tx_push = 0;
        @(posedge clk); #1;
        chk(cs_n == 0 && busy == 1, "R2 R10 frame start", cs_n, 0);
        chk(so == c[7], "R2 MSB on SO at start", so, c[7]);
        tr0 = total_rises;
        @(posedge cs_n); @(negedge clk);
        chk(busy == 0 && sk == 0 && so == 0, "R1 R10 back to idle", busy, 0);
        chk(ncmd == nc0 + 1 && cmd_log[nc0] == c, "R2 control byte", cmd_log[nc0], c);
        chk(total_rises - tr0 == 9 + el, "R3 R4 frame length", total_rises - tr0, 9 + el);
        chk(last_hp == time'(eh * 10), "R7 half period", int'(last_hp), eh * 10);
        chk(!rx_empty && rx_data == expv(c, el), "R5 R4 reply word", rx_data, expv(c, el));
        rx_pop = 1; @(negedge clk); rx_pop = 0;
        chk(rx_empty, "R8 rx empty after pop", rx_empty, 1);
      end
    end
    chk(so_bad == 0, "R3 SO low after command", so_bad, 0);
    chk(rx_overrun == 0, "R9 no overrun yet", rx_overrun, 0);

    // burst: back to back frames, dropped push, overrun
    begin
      automatic int nc0 = ncmd;
      automatic int cr0 = cs_rises;
      reply_len = 4; sk_half = 1; cur_len = 4;
      for (int i = 0; i < 10; i++) begin
        tx_data = 8'(8'hA0 + i); tx_push = 1;
        @(negedge clk);
      end
      tx_push = 0;
      chk(tx_full == 1, "R8 tx full", tx_full, 1);
      while (!(cs_n && tx_empty)) @(negedge clk);
      chk(cs_rises - cr0 == 1, "R6 cs held low between frames", cs_rises - cr0, 1);
      chk(ncmd - nc0 == 9, "R8 push to full tx dropped", ncmd - nc0, 9);
      chk(rx_full == 1, "R8 rx full", rx_full, 1);
      chk(rx_overrun == 1, "R9 overrun set", rx_overrun, 1);
      for (int i = 0; i < 8; i++) begin
        chk(rx_data == expv(8'(8'hA0 + i), 4), "R8 R9 rx order", rx_data, expv(8'(8'hA0 + i), 4));
        rx_pop = 1; @(negedge clk); rx_pop = 0;
      end
      chk(rx_empty == 1, "R9 ninth reply discarded", rx_empty, 1);
      chk(rx_overrun == 1, "R9 overrun sticky", rx_overrun, 1);
    end

    $display("%0d/%0d checks passed", npass, npass + nfail);
    $finish;
  end
endmodule